// File: doc/BRIEF.md
# Reduced-Swing Source-Driver Line Transmitter

This block accepts a pixel stream qualified only by a data-enable, two pixels per enabled clock, and replays each complete video line onto a reduced-swing source-driver bus. Every color is cut from 8 bits to a 6-bit word. That word is spread over three lanes, each carrying two bits per bus clock: one for the rising half and one for the falling half. The per-lane bit pairs feed an external double-data-rate output stage. One half of the panel is modelled.

A line buffer separates the bursty input from the output bus. A line goes out only once all of its pixels are stored, so the bus sends it without gaps. Around each line the block emits three control signals. A start pulse marks the first data clock. A load strobe, placed a set number of clocks after the last data clock, makes the column drivers latch on its rising edge and drive on its falling edge. A polarity signal inverts line by line and also per frame, and it changes only in the strobe-low window. If the buffer overflows, a sticky error flag is raised.

Top module: `rsds_line_tx`

## Requirements
- R1: After reset, every output is low: both lane buses, the start pulse, the load strobe, the polarity and the overflow flag.
- R2: A 24-bit input pixel holds red in [23:16], green in [15:8] and blue in [7:0]. Each color keeps its upper six bits as a word w. Lane k of a color (k = 0..2) carries w[2k] on `bus_even` and w[2k+1] on `bus_odd`. Lane indices are red 0..2, green 3..5 and blue 6..8.
- R3: A line is LINE_PAIRS enabled input clocks. It is sent as 2*LINE_PAIRS consecutive data clocks in arrival order, with `in_pix_a` before `in_pix_b` for each enabled clock.
- R4: `start_pulse` is high on the first data clock of each line and low on every other clock.
- R5: No data for a line leaves until its last pair is stored. The first data clock comes two clocks after the clock edge that stores that pair. Outside data clocks both lane buses are zero.
- R6: After the last data clock, `load_strobe` stays low for STB_GAP clocks and then is high for STB_WIDTH clocks.
- R7: `polarity` is constant from the first data clock of a line to the end of its strobe. It changes exactly POL_GAP clocks after the strobe falls, counting the first strobe-low clock as one.
- R8: During line n, counted from reset, polarity equals ((n mod FRAME_LINES) mod 2) XOR ((n div FRAME_LINES) mod 2).
- R9: An enabled input clock that finds the buffer full is dropped and sets `ovf_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_de | input | 1 | Data-enable; one pixel pair per high clock |
| in_pix_a | input | 24 | Earlier pixel of the pair |
| in_pix_b | input | 24 | Later pixel of the pair |
| bus_even | output | 9 | Rising-half bit of each lane |
| bus_odd | output | 9 | Falling-half bit of each lane |
| start_pulse | output | 1 | High on the first data clock of a line |
| load_strobe | output | 1 | Line-load strobe to the column drivers |
| polarity | output | 1 | Polarity-inversion control |
| ovf_err | output | 1 | Sticky buffer-overflow flag |

## Verification
The assertions take for granted that data-enable arrives in runs that add up to exactly LINE_PAIRS clocks per line. They also take for granted that, outside deliberate overload, the average input rate never outruns the bus drain, so the buffer is never popped while empty and full lines never pile up past its depth. The stimulus keeps to this by writing whole lines of fixed length with spacing that suits the drain rate. The single overflow scenario runs with output comparison suspended and is followed by a reset.

// File: rtl/rsds_tx_pkg.sv
package rsds_tx_pkg;
    localparam int COLOR_IN_W      = 8;
    localparam int LANE_WORD_W     = 6;
    localparam int NUM_COLORS      = 3;
    localparam int LANES_PER_COLOR = LANE_WORD_W / 2;
    localparam int BUS_LANES       = NUM_COLORS * LANES_PER_COLOR;
    localparam int PIX_IN_W        = NUM_COLORS * COLOR_IN_W;
    localparam int PIX_W           = NUM_COLORS * LANE_WORD_W;

    typedef logic [PIX_IN_W-1:0] pix_in_t;
    typedef logic [PIX_W-1:0]    pix6_t;

    typedef struct packed {
        logic  last;
        pix6_t pa;
        pix6_t pb;
    } buf_word_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DATA,
        SQ_GAP,
        SQ_STB,
        SQ_POST
    } seq_state_e;

    // Keep the upper bits of each color; red ends up in the top field.
    function automatic pix6_t to_lane_word(pix_in_t p);
        pix6_t w;
        for (int c = 0; c < NUM_COLORS; c++) begin
            w[c*LANE_WORD_W +: LANE_WORD_W] =
                p[c*COLOR_IN_W + (COLOR_IN_W-LANE_WORD_W) +: LANE_WORD_W];
        end
        return w;
    endfunction
endpackage

// File: rtl/rsds_line_buf.sv
module rsds_line_buf
    import rsds_tx_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  buf_word_t push_word,
    input  logic      pop,
    input  logic      line_take,
    output buf_word_t head,
    output logic      empty,
    output logic      line_avail,
    output logic      ovf_err
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]  wr;
        logic [AW-1:0]  rd;
        logic [CNW-1:0] count;
        logic [CNW-1:0] lines;
        logic           ovf;
    } buf_st_t;

    buf_st_t   st_q, st_d;
    buf_word_t mem [DEPTH];
    logic      full;
    logic      accept;

    assign full       = (st_q.count == CNW'(DEPTH));
    assign accept     = push && !full;
    assign empty      = (st_q.count == '0);
    assign line_avail = (st_q.lines != '0);
    assign head       = mem[st_q.rd];
    assign ovf_err    = st_q.ovf;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.wr = (st_q.wr == AW'(DEPTH-1)) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH-1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.count = st_q.count + CNW'(accept) - CNW'(pop);
        st_d.lines = st_q.lines + CNW'(accept && push_word.last) - CNW'(line_take);
        st_d.ovf   = st_q.ovf | (push && full);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[st_q.wr] <= push_word;
    end

    assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_take_needs_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_take |-> line_avail);
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
endmodule

// File: rtl/rsds_line_seq.sv
module rsds_line_seq
    import rsds_tx_pkg::*;
#(
    parameter int FRAME_LINES = 1050,
    parameter int STB_GAP     = 1,
    parameter int STB_WIDTH   = 2,
    parameter int POL_GAP     = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  buf_word_t head,
    input  logic      line_avail,
    output logic      pop,
    output logic      line_take,
    output pix6_t     pix_out,
    output logic      data_valid,
    output logic      start_pulse,
    output logic      load_strobe,
    output logic      polarity
);
    localparam int MAX_AB = (STB_GAP > STB_WIDTH) ? STB_GAP : STB_WIDTH;
    localparam int MAXC   = (MAX_AB > POL_GAP) ? MAX_AB : POL_GAP;
    localparam int CNTW   = $clog2(MAXC + 1);
    localparam int LW     = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1;

    typedef struct packed {
        seq_state_e     st;
        logic           sel;
        logic           last;
        logic [CNTW-1:0] cnt;
        logic [LW-1:0]  line_idx;
        logic           frame_par;
        pix6_t          pix;
        logic           valid;
        logic           start;
        logic           strobe;
    } seq_st_t;

    seq_st_t q, d;

    always_comb begin
        d         = q;
        pop       = 1'b0;
        line_take = 1'b0;
        d.pix     = '0;
        d.valid   = 1'b0;
        d.start   = 1'b0;
        d.strobe  = 1'b0;
        unique case (q.st)
            SQ_IDLE: begin
                if (line_avail) begin
                    line_take = 1'b1;
                    d.st      = SQ_DATA;
                    d.sel     = 1'b0;
                    d.pix     = head.pa;
                    d.valid   = 1'b1;
                    d.start   = 1'b1;
                end
            end
            SQ_DATA: begin
                if (!q.sel) begin
                    pop     = 1'b1;
                    d.last  = head.last;
                    d.sel   = 1'b1;
                    d.pix   = head.pb;
                    d.valid = 1'b1;
                end else if (q.last) begin
                    d.st  = SQ_GAP;
                    d.cnt = '0;
                end else begin
                    d.sel   = 1'b0;
                    d.pix   = head.pa;
                    d.valid = 1'b1;
                end
            end
            SQ_GAP: begin
                if (q.cnt == CNTW'(STB_GAP-1)) begin
                    d.st     = SQ_STB;
                    d.cnt    = '0;
                    d.strobe = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_STB: begin
                if (q.cnt == CNTW'(STB_WIDTH-1)) begin
                    d.st  = SQ_POST;
                    d.cnt = '0;
                end else begin
                    d.cnt    = q.cnt + 1'b1;
                    d.strobe = 1'b1;
                end
            end
            SQ_POST: begin
                if (q.cnt == CNTW'(POL_GAP-1)) begin
                    d.st = SQ_IDLE;
                    if (q.line_idx == LW'(FRAME_LINES-1)) begin
                        d.line_idx  = '0;
                        d.frame_par = ~q.frame_par;
                    end else begin
                        d.line_idx = q.line_idx + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: SQ_IDLE, default: '0};
        else        q <= d;
    end

    assign pix_out     = q.pix;
    assign data_valid  = q.valid;
    assign start_pulse = q.start;
    assign load_strobe = q.strobe;
    assign polarity    = q.line_idx[0] ^ q.frame_par;

    assert_pol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> $stable(polarity));
    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    assert_gap_before_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !load_strobe);
    assert_pol_in_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !start_pulse) |-> $stable(polarity));
endmodule

// File: rtl/rsds_lane_map.sv
module rsds_lane_map
    import rsds_tx_pkg::*;
(
    input  pix6_t                pix,
    output logic [BUS_LANES-1:0] lane_even,
    output logic [BUS_LANES-1:0] lane_odd
);
    for (genvar c = 0; c < NUM_COLORS; c++) begin : g_color
        // Red occupies the top field of pix and lanes 0..2.
        localparam int FIELD = (NUM_COLORS - 1 - c) * LANE_WORD_W;
        for (genvar k = 0; k < LANES_PER_COLOR; k++) begin : g_lane
            assign lane_even[c*LANES_PER_COLOR + k] = pix[FIELD + 2*k];
            assign lane_odd[c*LANES_PER_COLOR + k]  = pix[FIELD + 2*k + 1];
        end
    end
endmodule

// File: rtl/rsds_line_tx.sv
module rsds_line_tx
    import rsds_tx_pkg::*;
#(
    parameter int LINE_PAIRS  = 840,
    parameter int FRAME_LINES = 1050,
    parameter int BUF_DEPTH   = 1024,
    parameter int STB_GAP     = 1,
    parameter int STB_WIDTH   = 2,
    parameter int POL_GAP     = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_de,
    input  logic [23:0] in_pix_a,
    input  logic [23:0] in_pix_b,
    output logic [8:0]  bus_even,
    output logic [8:0]  bus_odd,
    output logic        start_pulse,
    output logic        load_strobe,
    output logic        polarity,
    output logic        ovf_err
);
    localparam int COLW = (LINE_PAIRS > 1) ? $clog2(LINE_PAIRS) : 1;

    typedef struct packed {
        logic [COLW-1:0] col;
    } in_st_t;

    in_st_t    in_q, in_d;
    logic      at_end;
    buf_word_t push_word;
    buf_word_t head;
    logic      pop, line_take, empty, line_avail;
    pix6_t     pix_out;
    logic      data_valid;

    assign at_end    = (in_q.col == COLW'(LINE_PAIRS-1));
    assign push_word = '{last: at_end,
                         pa:   to_lane_word(in_pix_a),
                         pb:   to_lane_word(in_pix_b)};

    always_comb begin
        in_d = in_q;
        if (in_de) in_d.col = at_end ? '0 : in_q.col + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    rsds_line_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (in_de),
        .push_word  (push_word),
        .pop        (pop),
        .line_take  (line_take),
        .head       (head),
        .empty      (empty),
        .line_avail (line_avail),
        .ovf_err    (ovf_err)
    );

    rsds_line_seq #(
        .FRAME_LINES (FRAME_LINES),
        .STB_GAP     (STB_GAP),
        .STB_WIDTH   (STB_WIDTH),
        .POL_GAP     (POL_GAP)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .head        (head),
        .line_avail  (line_avail),
        .pop         (pop),
        .line_take   (line_take),
        .pix_out     (pix_out),
        .data_valid  (data_valid),
        .start_pulse (start_pulse),
        .load_strobe (load_strobe),
        .polarity    (polarity)
    );

    rsds_lane_map u_map (
        .pix       (pix_out),
        .lane_even (bus_even),
        .lane_odd  (bus_odd)
    );

    assert_bus_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> (bus_even == '0 && bus_odd == '0));
    assert_start_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> data_valid);
endmodule

// File: tb/sim_rsds_line_tx.sv
module sim_rsds_line_tx;
    localparam int LP = 4;
    localparam int FL = 2;
    localparam int DEPTH = 16;
    localparam int SG = 1;
    localparam int SW = 2;
    localparam int PG = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_de = 1'b0;
    logic [23:0] in_pix_a = '0;
    logic [23:0] in_pix_b = '0;
    logic [8:0]  bus_even, bus_odd;
    logic        start_pulse, load_strobe, polarity, ovf_err;

    int compared = 0;
    int mismatched = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    int lines_seen = 0;
    logic [17:0] exp_q[$];

    always #10 clk = ~clk;

    rsds_line_tx #(
        .LINE_PAIRS(LP), .FRAME_LINES(FL), .BUF_DEPTH(DEPTH),
        .STB_GAP(SG), .STB_WIDTH(SW), .POL_GAP(PG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_de(in_de),
        .in_pix_a(in_pix_a), .in_pix_b(in_pix_b),
        .bus_even(bus_even), .bus_odd(bus_odd),
        .start_pulse(start_pulse), .load_strobe(load_strobe),
        .polarity(polarity), .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // R2: expected {even, odd} lanes from the 8-bit colors
    function automatic logic [17:0] lanes_of(logic [23:0] px);
        logic [8:0] e, o;
        for (int c = 0; c < 3; c++) begin
            logic [7:0] col;
            col = px[23-8*c -: 8];
            for (int k = 0; k < 3; k++) begin
                e[c*3+k] = col[2+2*k];
                o[c*3+k] = col[3+2*k];
            end
        end
        return {e, o};
    endfunction

    function automatic logic pol_model(int n);
        return logic'(((n % FL) % 2) ^ ((n / FL) % 2));
    endfunction

    function automatic logic [23:0] pat(int ln, int p, int h);
        return {8'(ln*53 + p*29 + h*7 + 3), 8'(ln*17 + p*91 + h*113 + 8'h5A), 8'(ln*201 + p*13 + h*47 + 8'hC1)};
    endfunction

    // Driver: one line; spacing = idle clocks after each enabled clock
    task automatic drive_line(input int ln, input int spacing, input int kind);
        for (int p = 0; p < LP; p++) begin
            logic [23:0] a, b;
            a = (kind == 1) ? 24'hFFFFFF : (kind == 2) ? 24'h030303 : pat(ln, p, 0);
            b = (kind == 1) ? 24'hFFFFFF : (kind == 2) ? 24'h030303 : pat(ln, p, 1);
            @(negedge clk);
            in_de = 1'b1; in_pix_a = a; in_pix_b = b;
            if (mon_en) begin
                exp_q.push_back(lanes_of(a));
                exp_q.push_back(lanes_of(b));
            end
            for (int s = 0; s < spacing; s++) begin
                @(negedge clk);
                in_de = 1'b0;
            end
        end
        @(negedge clk);
        in_de = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: scoreboard comparison of each transmitted line
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rst_n) begin
                if (start_pulse) begin
                    logic lp;
                    lp = polarity;
                    chk(lp == pol_model(lines_seen), "R8", 32'(lp), 32'(pol_model(lines_seen)));
                    for (int i = 0; i < 2*LP; i++) begin
                        logic [17:0] e;
                        e = (exp_q.size() > 0) ? exp_q.pop_front() : 18'h3FFFF;
                        chk({bus_even, bus_odd} == e, "R2/R3", 32'({bus_even, bus_odd}), 32'(e));
                        chk(start_pulse == (i == 0), "R4", 32'(start_pulse), 32'(i == 0));
                        chk(polarity == lp, "R7", 32'(polarity), 32'(lp));
                        if (i < 2*LP-1) @(negedge clk);
                    end
                    for (int g = 0; g < SG; g++) begin
                        @(negedge clk);
                        chk(!load_strobe, "R6", 32'(load_strobe), 0);
                        chk(bus_even == 0 && bus_odd == 0, "R5", 32'({bus_even, bus_odd}), 0);
                    end
                    for (int w = 0; w < SW; w++) begin
                        @(negedge clk);
                        chk(load_strobe, "R6", 32'(load_strobe), 1);
                        chk(polarity == lp, "R7", 32'(polarity), 32'(lp));
                    end
                    for (int g = 0; g < PG; g++) begin
                        @(negedge clk);
                        chk(!load_strobe, "R6", 32'(load_strobe), 0);
                        chk(polarity == lp, "R7", 32'(polarity), 32'(lp));
                    end
                    @(negedge clk);
                    lines_seen++;
                    chk(polarity == pol_model(lines_seen), "R7", 32'(polarity), 32'(pol_model(lines_seen)));
                end else begin
                    chk(bus_even == 0 && bus_odd == 0, "R5", 32'({bus_even, bus_odd}), 0);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        // R1: reset state
        chk({bus_even, bus_odd, start_pulse, load_strobe, polarity, ovf_err} == 0, "R1",
            32'({bus_even, bus_odd, start_pulse, load_strobe, polarity, ovf_err}), 0);
        rst_n = 1'b1;
        idle(2);
        mon_en = 1'b1;

        // Spaced lines, several patterns, two frames of polarity
        for (int ln = 0; ln < 5; ln++) begin
            drive_line(ln, 1, (ln == 3) ? 1 : (ln == 4) ? 2 : 0);
            idle(6);
        end
        // Back-to-back enables within a line
        drive_line(7, 0, 0);
        idle(40);

        // R5: slow line, nothing leaves before the last pair is stored
        for (int p = 0; p < LP; p++) begin
            logic [23:0] a, b;
            a = pat(9, p, 0); b = pat(9, p, 1);
            @(negedge clk);
            in_de = 1'b1; in_pix_a = a; in_pix_b = b;
            exp_q.push_back(lanes_of(a));
            exp_q.push_back(lanes_of(b));
            @(negedge clk);
            in_de = 1'b0;
            chk(!start_pulse, "R5", 32'(start_pulse), 0);
            if (p < LP-1) begin
                idle(4);
                chk(!start_pulse, "R5", 32'(start_pulse), 0);
            end else begin
                @(negedge clk);
                chk(start_pulse, "R5", 32'(start_pulse), 1);
            end
        end
        idle(40);
        chk(exp_q.size() == 0, "R3", 32'(exp_q.size()), 0);
        chk(lines_seen == 7, "R3", 32'(lines_seen), 7);
        chk(!ovf_err, "R9", 32'(ovf_err), 0);

        // R9: overload, comparison suspended
        mon_en = 1'b0;
        @(negedge clk);
        for (int p = 0; p < 10*LP; p++) begin
            in_de = 1'b1; in_pix_a = pat(p, 0, 0); in_pix_b = pat(p, 1, 1);
            @(negedge clk);
        end
        in_de = 1'b0;
        chk(ovf_err, "R9", 32'(ovf_err), 1);
        idle(100);
        chk(ovf_err, "R9", 32'(ovf_err), 1);

        // R1: reset clears everything, including the sticky flag
        rst_n = 1'b0;
        idle(2);
        chk({bus_even, bus_odd, start_pulse, load_strobe, polarity, ovf_err} == 0, "R1",
            32'({bus_even, bus_odd, start_pulse, load_strobe, polarity, ovf_err}), 0);
        rst_n = 1'b1;
        exp_q.delete();
        lines_seen = 0;
        idle(2);
        mon_en = 1'b1;
        drive_line(20, 1, 0);
        idle(40);
        chk(lines_seen == 1, "R3", 32'(lines_seen), 1);
        chk(!ovf_err, "R9", 32'(ovf_err), 0);
        finish_run();
    end
endmodule